// File: doc/BRIEF.md
# Programmed-I/O Sector Read Sequencer

This block paces programmed-I/O reads of a disk's data port. A read command loads a transfer length, measured in 512-byte sectors, and the block asks an attached sector source for the first sector. The source fills a one-sector buffer and then signals that the sector is ready. The host then pulls data through 2-byte or 4-byte read strobes. The block counts the bytes it has handed out. When a read strobe arrives at a sector boundary, the block stalls that strobe, requests the next logical block, and returns the data once the new sector has landed.

The block also decides when to interrupt the host and drives the status bits: busy, ready, data-request and error. The single-sector read commands interrupt after every sector. The multiple-sector read interrupts once per block of sectors, and the set-multiple command sets the size of that block. The last byte of a transfer always raises an interrupt. Reads past the end of a transfer are reported as overruns.

Top module: `pio_read_pacer`

## Requirements
- R1: After reset the status is ready=1, busy=0, data-request=0, error=0, and the configured multiple-sector count is 1.
- R2: A command of 0x20, 0x21 or 0x24 (single-sector reads) or 0xC4 (multiple-sector read) with sector count N loads a transfer of N×512 bytes, where N=0 means 256. In the cycle after the command it pulses the sector request with the command's start address, sets busy=1 and clears ready and data-request. When sector-ready arrives, busy clears and ready and data-request set.
- R3: Each accepted strobe returns data one cycle later together with a valid pulse. A 4-byte access returns the 32-bit word holding byte index i, with byte 0 in bits 7:0. A 2-byte access returns the half of that word chosen by index bit 1, zero-extended. The index then advances by 4 or by 2.
- R4: A strobe that arrives with the index a non-zero multiple of 512, and still below the length, requests the address one above the previous request. It shows busy=1 and data-request=0, and returns its data from offset 0 of the new sector only after sector-ready.
- R5: An interrupt pulse accompanies the data of a read after which the index is a multiple of 512×B or equals the length. B is 1 for 0x20, 0x21 and 0x24, and B is the configured multiple-sector count for 0xC4. No other read interrupts.
- R6: At an interrupt inside a transfer, data-request stays 1. At the interrupt of the final read, data-request clears. In both cases busy=0 and ready=1.
- R7: A strobe when the index is at or past the length returns no data and no interrupt, sets error, and does not move the index, so a repeated strobe is also an overrun.
- R8: Command 0xC6 with sector count 1..16 sets the multiple-sector count to that value. A count of 0 sets it to 1. The command then sets ready, clears error and pulses the interrupt.
- R9: Command 0xC6 with a sector count above 16 aborts: error=1, ready=1, an interrupt pulse, and the multiple-sector count is unchanged.
- R10: While busy, read strobes and commands are ignored: no data, no error change, no interrupt, and the transfer continues from the same index.
- R11: Any other command code aborts. It sets error=1, ready=1 and data-request=0, pulses the interrupt, and ends the transfer so that later strobes are overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_sect_cnt | input | SC_W | Sector count register value |
| cmd_lba | input | LBA_W | Start logical block address for read commands |
| rd_stb | input | 1 | Data-port read strobe |
| rd_wide | input | 1 | Access width: 1 = 4 bytes, 0 = 2 bytes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| src_req | output | 1 | Next-sector request pulse |
| src_lba | output | LBA_W | Address of the requested sector |
| src_we | input | 1 | Sector buffer write enable from source |
| src_waddr | input | SECT_LG2-log2(DW/8) | Word address in sector buffer |
| src_wdata | input | DW | Sector buffer write data |
| src_ready | input | 1 | Requested sector fully written |
| st_busy | output | 1 | Status: busy |
| st_ready | output | 1 | Status: ready |
| st_drq | output | 1 | Status: data request |
| st_err | output | 1 | Status: error |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench checks where interrupts fall for block sizes that do and do not divide the transfer, such as 7 sectors in blocks of 3 and 6 in blocks of 4. A design that keeps no per-block count, or that omits the final-byte interrupt, would drop or add pulses in these cases. Both access widths are read across every sector boundary. This catches a design that returns stale data from the old sector or steps the address wrongly. The bench also covers a count of 0 meaning 256 sectors, set-multiple with 0 and with a value above 16 (where an off-by-one limit or a corrupted count shows up in the next transfer's pacing), and strobes and commands issued while busy, which a careless design would let move the index. Overruns after the end of a transfer are checked twice, which exposes an index that creeps forward.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;

  localparam logic [7:0] OP_RD_RETRY   = 8'h20;
  localparam logic [7:0] OP_RD_NORETRY = 8'h21;
  localparam logic [7:0] OP_RD_EXT     = 8'h24;
  localparam logic [7:0] OP_RD_BLOCK   = 8'hC4;
  localparam logic [7:0] OP_SET_BLOCK  = 8'hC6;

  typedef enum logic [1:0] {
    CK_READ    = 2'd0,
    CK_SETMULT = 2'd1,
    CK_ABORT   = 2'd2
  } cmd_kind_e;

  typedef enum logic {
    SQ_RUN  = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/pio_rd_cmd.sv
module pio_rd_cmd
  import pio_rd_pkg::*;
#(
  parameter int SC_W     = 8,
  parameter int SECT_LG2 = 9,
  parameter int MAX_MULT = 16,
  parameter int MULT_W   = $clog2(MAX_MULT + 1),
  parameter int LEN_W    = SC_W + 1 + SECT_LG2
) (
  input  logic [7:0]        code,
  input  logic [SC_W-1:0]   sect_cnt,
  input  logic [MULT_W-1:0] mult_cur,
  output cmd_kind_e         kind,
  output logic [MULT_W-1:0] blk_sz,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              mult_ok,
  output logic [MULT_W-1:0] mult_new
);

  logic [SC_W:0] n_sect;

  // a zero count stands for the full 2**SC_W sectors
  always_comb begin
    if (sect_cnt == '0) n_sect = {1'b1, {SC_W{1'b0}}};
    else                n_sect = {1'b0, sect_cnt};
  end

  assign xfer_len = {n_sect, {SECT_LG2{1'b0}}};

  always_comb begin
    kind   = CK_ABORT;
    blk_sz = MULT_W'(1);
    unique case (code)
      OP_RD_RETRY, OP_RD_NORETRY, OP_RD_EXT: kind = CK_READ;
      OP_RD_BLOCK: begin
        kind   = CK_READ;
        blk_sz = mult_cur;
      end
      OP_SET_BLOCK: kind = CK_SETMULT;
      default: kind = CK_ABORT;
    endcase
  end

  assign mult_ok  = (sect_cnt <= SC_W'(MAX_MULT));
  assign mult_new = (sect_cnt == '0) ? MULT_W'(1) : sect_cnt[MULT_W-1:0];

endmodule

// File: rtl/pio_rd_buf.sv
module pio_rd_buf #(
  parameter int DW       = 32,
  parameter int WA_W     = 7,
  parameter int WORDS    = 2 ** WA_W
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [WA_W-1:0] rd_addr,
  input  logic            rd_hi,
  input  logic            rd_wide,
  output logic [DW-1:0]   rd_data
);

  localparam int HALF = DW / 2;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] q;
  logic          hi_q;
  logic          wide_q;

  // single write port, single registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) begin
      q      <= mem[rd_addr];
      hi_q   <= rd_hi;
      wide_q <= rd_wide;
    end
  end

  always_comb begin
    if (wide_q)    rd_data = q;
    else if (hi_q) rd_data = {{HALF{1'b0}}, q[DW-1:HALF]};
    else           rd_data = {{HALF{1'b0}}, q[HALF-1:0]};
  end

endmodule

// File: rtl/pio_rd_ctrl.sv
module pio_rd_ctrl
  import pio_rd_pkg::*;
#(
  parameter int LEN_W    = 18,
  parameter int SECT_LG2 = 9,
  parameter int LANE_LG2 = 2,
  parameter int MULT_W   = 5,
  parameter int LBA_W    = 28
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  cmd_kind_e                    kind,
  input  logic [MULT_W-1:0]            blk_new,
  input  logic [LEN_W-1:0]             len_new,
  input  logic                         mult_ok,
  input  logic [MULT_W-1:0]            mult_new,
  input  logic [LBA_W-1:0]             lba_in,
  input  logic                         rd_stb,
  input  logic                         rd_wide,
  input  logic                         src_ready,
  output logic [MULT_W-1:0]            mult_cur,
  output logic                         buf_rd_en,
  output logic [SECT_LG2-LANE_LG2-1:0] buf_waddr,
  output logic                         buf_hi,
  output logic                         buf_wide,
  output logic                         rd_valid,
  output logic                         src_req,
  output logic [LBA_W-1:0]             src_lba,
  output logic                         busy,
  output logic                         ready,
  output logic                         drq,
  output logic                         err,
  output logic                         irq
);

  localparam logic [LEN_W-1:0] STEP_WIDE   = LEN_W'(2 ** LANE_LG2);
  localparam logic [LEN_W-1:0] STEP_NARROW = LEN_W'(2 ** (LANE_LG2 - 1));

  seq_state_e         state;
  logic [LEN_W-1:0]   idx;
  logic [LEN_W-1:0]   len;
  logic [MULT_W-1:0]  blk;
  logic [MULT_W-1:0]  sect_in_blk;
  logic               pend;
  logic               pend_wide;

  logic               cmd_go;
  logic               strobe_run;
  logic               at_bound;
  logic               go_fetch;
  logic               go_read;
  logic               resume;
  logic               do_read;
  logic               acc_wide;
  logic [LEN_W-1:0]   idx_nxt;
  logic               sect_done;
  logic               blk_done;
  logic               fire;
  logic               overrun;

  // commands are only taken while no sector fetch is outstanding
  assign cmd_go     = cmd_valid && !busy;
  assign strobe_run = (state == SQ_RUN) && rd_stb && !cmd_valid;
  assign at_bound   = (idx[SECT_LG2-1:0] == '0) && (idx != '0);
  assign overrun    = strobe_run && (idx >= len);
  assign go_fetch   = strobe_run && (idx < len) && at_bound;
  assign go_read    = strobe_run && (idx < len) && !at_bound;
  assign resume     = (state == SQ_WAIT) && src_ready;
  assign do_read    = go_read || (resume && pend);
  assign acc_wide   = (state == SQ_WAIT) ? pend_wide : rd_wide;
  assign idx_nxt    = idx + (acc_wide ? STEP_WIDE : STEP_NARROW);
  assign sect_done  = (idx_nxt[SECT_LG2-1:0] == '0);
  assign blk_done   = sect_done && ((sect_in_blk + MULT_W'(1)) == blk);
  assign fire       = do_read && (blk_done || (idx_nxt == len));

  assign buf_rd_en  = do_read;
  assign buf_waddr  = idx[SECT_LG2-1:LANE_LG2];
  assign buf_hi     = idx[LANE_LG2-1];
  assign buf_wide   = acc_wide;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_RUN;
      idx         <= '0;
      len         <= '0;
      blk         <= MULT_W'(1);
      mult_cur    <= MULT_W'(1);
      sect_in_blk <= '0;
      pend        <= 1'b0;
      pend_wide   <= 1'b0;
      src_lba     <= '0;
      src_req     <= 1'b0;
      rd_valid    <= 1'b0;
      busy        <= 1'b0;
      ready       <= 1'b1;
      drq         <= 1'b0;
      err         <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq      <= 1'b0;
      src_req  <= 1'b0;
      rd_valid <= do_read;

      if (cmd_go) begin
        unique case (kind)
          CK_READ: begin
            len         <= len_new;
            blk         <= blk_new;
            idx         <= '0;
            sect_in_blk <= '0;
            src_lba     <= lba_in;
            src_req     <= 1'b1;
            pend        <= 1'b0;
            state       <= SQ_WAIT;
            busy        <= 1'b1;
            ready       <= 1'b0;
            drq         <= 1'b0;
            err         <= 1'b0;
          end
          CK_SETMULT: begin
            if (mult_ok) mult_cur <= mult_new;
            err   <= !mult_ok;
            ready <= 1'b1;
            irq   <= 1'b1;
          end
          default: begin
            len   <= '0;
            idx   <= '0;
            pend  <= 1'b0;
            state <= SQ_RUN;
            err   <= 1'b1;
            ready <= 1'b1;
            drq   <= 1'b0;
            irq   <= 1'b1;
          end
        endcase
      end else begin
        if (overrun) err <= 1'b1;

        if (go_fetch) begin
          state     <= SQ_WAIT;
          src_lba   <= src_lba + LBA_W'(1);
          src_req   <= 1'b1;
          pend      <= 1'b1;
          pend_wide <= rd_wide;
          busy      <= 1'b1;
          ready     <= 1'b0;
          drq       <= 1'b0;
        end

        if (resume) begin
          state <= SQ_RUN;
          pend  <= 1'b0;
          busy  <= 1'b0;
          ready <= 1'b1;
          drq   <= 1'b1;
        end

        if (do_read) begin
          idx <= idx_nxt;
          if (sect_done) sect_in_blk <= blk_done ? '0 : sect_in_blk + MULT_W'(1);
          if (fire) begin
            irq   <= 1'b1;
            busy  <= 1'b0;
            ready <= 1'b1;
            drq   <= (idx_nxt != len);
          end
        end
      end
    end
  end

endmodule

// File: rtl/pio_read_pacer.sv
module pio_read_pacer
  import pio_rd_pkg::*;
#(
  parameter int SC_W     = 8,
  parameter int SECT_LG2 = 9,
  parameter int DW       = 32,
  parameter int MAX_MULT = 16,
  parameter int LBA_W    = 28
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cmd_valid,
  input  logic [7:0]                             cmd_code,
  input  logic [SC_W-1:0]                        cmd_sect_cnt,
  input  logic [LBA_W-1:0]                       cmd_lba,
  input  logic                                   rd_stb,
  input  logic                                   rd_wide,
  output logic                                   rd_valid,
  output logic [DW-1:0]                          rd_data,
  output logic                                   src_req,
  output logic [LBA_W-1:0]                       src_lba,
  input  logic                                   src_we,
  input  logic [SECT_LG2-$clog2(DW/8)-1:0]       src_waddr,
  input  logic [DW-1:0]                          src_wdata,
  input  logic                                   src_ready,
  output logic                                   st_busy,
  output logic                                   st_ready,
  output logic                                   st_drq,
  output logic                                   st_err,
  output logic                                   irq
);

  localparam int LANE_LG2 = $clog2(DW / 8);
  localparam int WA_W     = SECT_LG2 - LANE_LG2;
  localparam int LEN_W    = SC_W + 1 + SECT_LG2;
  localparam int MULT_W   = $clog2(MAX_MULT + 1);

  cmd_kind_e          kind;
  logic [MULT_W-1:0]  blk_new;
  logic [LEN_W-1:0]   len_new;
  logic               mult_ok;
  logic [MULT_W-1:0]  mult_new;
  logic [MULT_W-1:0]  mult_cur;
  logic               buf_rd_en;
  logic [WA_W-1:0]    buf_waddr;
  logic               buf_hi;
  logic               buf_wide;

  pio_rd_cmd #(
    .SC_W(SC_W), .SECT_LG2(SECT_LG2), .MAX_MULT(MAX_MULT),
    .MULT_W(MULT_W), .LEN_W(LEN_W)
  ) u_cmd (
    .code(cmd_code), .sect_cnt(cmd_sect_cnt), .mult_cur(mult_cur),
    .kind(kind), .blk_sz(blk_new), .xfer_len(len_new),
    .mult_ok(mult_ok), .mult_new(mult_new)
  );

  pio_rd_ctrl #(
    .LEN_W(LEN_W), .SECT_LG2(SECT_LG2), .LANE_LG2(LANE_LG2),
    .MULT_W(MULT_W), .LBA_W(LBA_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .kind(kind),
    .blk_new(blk_new), .len_new(len_new), .mult_ok(mult_ok),
    .mult_new(mult_new), .lba_in(cmd_lba), .rd_stb(rd_stb),
    .rd_wide(rd_wide), .src_ready(src_ready), .mult_cur(mult_cur),
    .buf_rd_en(buf_rd_en), .buf_waddr(buf_waddr), .buf_hi(buf_hi),
    .buf_wide(buf_wide), .rd_valid(rd_valid), .src_req(src_req),
    .src_lba(src_lba), .busy(st_busy), .ready(st_ready), .drq(st_drq),
    .err(st_err), .irq(irq)
  );

  pio_rd_buf #(
    .DW(DW), .WA_W(WA_W)
  ) u_buf (
    .clk(clk), .wr_en(src_we), .wr_addr(src_waddr), .wr_data(src_wdata),
    .rd_en(buf_rd_en), .rd_addr(buf_waddr), .rd_hi(buf_hi),
    .rd_wide(buf_wide), .rd_data(rd_data)
  );

endmodule

// File: rtl/pio_read_pacer_chk.sv
module pio_read_pacer_chk #(
  parameter int LBA_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             rd_stb,
  input logic             rd_valid,
  input logic             src_req,
  input logic [LBA_W-1:0] src_lba,
  input logic             st_busy,
  input logic             st_ready,
  input logic             st_drq,
  input logic             st_err,
  input logic             irq
);

  // R2: data request is never offered while a sector is outstanding
  p_busy_no_drq_r2: assert property (@(posedge clk) disable iff (rst)
    st_busy |-> !st_drq);

  // R4: a sector request always leaves the block busy
  p_req_busy_r4: assert property (@(posedge clk) disable iff (rst)
    src_req |-> st_busy);

  // R4: a boundary fetch asks for the next address
  p_lba_step_r4: assert property (@(posedge clk) disable iff (rst)
    (src_req && !$past(cmd_valid)) |-> (src_lba == $past(src_lba) + LBA_W'(1)));

  // R6: every interrupt is given with busy clear and ready set
  p_irq_status_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!st_busy && st_ready));

  // R7: a strobe with nothing left to hand out yields no data and flags error
  p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !cmd_valid && !st_busy && !st_drq) |=> (!rd_valid && st_err));

  // R10: data is never delivered while busy
  p_no_data_busy_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !st_busy);

endmodule

bind pio_read_pacer pio_read_pacer_chk #(.LBA_W(LBA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .rd_stb(rd_stb),
  .rd_valid(rd_valid), .src_req(src_req), .src_lba(src_lba),
  .st_busy(st_busy), .st_ready(st_ready), .st_drq(st_drq),
  .st_err(st_err), .irq(irq)
);

// File: tb/pio_read_pacer_test.sv
module pio_read_pacer_test;

  localparam int LBA_W = 28;
  localparam int NV    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [7:0]  cmd_sect_cnt = '0;
  logic [27:0] cmd_lba = '0;
  logic        rd_stb = 1'b0;
  logic        rd_wide = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        src_req;
  logic [27:0] src_lba;
  logic        src_we = 1'b0;
  logic [6:0]  src_waddr = '0;
  logic [31:0] src_wdata = '0;
  logic        src_ready = 1'b0;
  logic        st_busy, st_ready, st_drq, st_err, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pio_read_pacer uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_sect_cnt(cmd_sect_cnt), .cmd_lba(cmd_lba), .rd_stb(rd_stb),
    .rd_wide(rd_wide), .rd_valid(rd_valid), .rd_data(rd_data),
    .src_req(src_req), .src_lba(src_lba), .src_we(src_we),
    .src_waddr(src_waddr), .src_wdata(src_wdata), .src_ready(src_ready),
    .st_busy(st_busy), .st_ready(st_ready), .st_drq(st_drq),
    .st_err(st_err), .irq(irq)
  );

  // fields: set-multiple value (FF = skip), command, sector count, wide, expected irqs
  localparam logic [39:0] VEC [NV] = '{
    {8'hFF, 8'h20, 8'h03, 8'h01, 8'd3},
    {8'hFF, 8'h21, 8'h02, 8'h00, 8'd2},
    {8'hFF, 8'h24, 8'h01, 8'h01, 8'd1},
    {8'h04, 8'hC4, 8'h06, 8'h01, 8'd2},
    {8'h03, 8'hC4, 8'h07, 8'h00, 8'd3},
    {8'h00, 8'hC4, 8'h02, 8'h01, 8'd2},
    {8'h10, 8'hC4, 8'h05, 8'h01, 8'd1},
    {8'h10, 8'hC4, 8'h00, 8'h01, 8'd16}
  };

  function automatic logic [31:0] pat(input logic [27:0] l, input int w);
    logic [6:0] wv;
    wv = w[6:0];
    return {l[7:0], 1'b0, wv, l[7:0] ^ 8'hFF, 1'b1, wv};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sector source model
  initial begin
    forever begin
      @(negedge clk);
      if (src_req) begin
        logic [27:0] l;
        l = src_lba;
        for (int w = 0; w < 128; w++) begin
          src_we = 1'b1; src_waddr = w[6:0]; src_wdata = pat(l, w);
          @(negedge clk);
        end
        src_we = 1'b0;
        src_ready = 1'b1;
        @(negedge clk);
        src_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  logic        r_valid, r_irq, r_waited, r_busy1, r_drq1;
  logic [31:0] r_data;
  logic [27:0] r_lba1;

  task automatic issue_cmd(input logic [7:0] c, input logic [7:0] sc, input logic [27:0] l);
    cmd_valid = 1'b1; cmd_code = c; cmd_sect_cnt = sc; cmd_lba = l;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input bit wide);
    rd_stb = 1'b1; rd_wide = wide;
    @(negedge clk);
    rd_stb = 1'b0;
    r_waited = 1'b0;
    r_busy1 = st_busy; r_drq1 = st_drq; r_lba1 = src_lba;
    if (!rd_valid && st_busy) begin
      r_waited = 1'b1;
      for (int t = 0; t < 400 && !rd_valid; t++) @(negedge clk);
    end
    r_valid = rd_valid; r_data = rd_data; r_irq = irq;
  endtask

  task automatic wait_drq();
    for (int t = 0; t < 400 && !st_drq; t++) @(negedge clk);
  endtask

  task automatic run_xfer(input logic [7:0] c, input logic [7:0] sc, input logic [27:0] l,
                          input bit wide, input int blk, input int exp_irqs, input bit poke);
    int nsec, len, idx, irqs;
    nsec = (sc == 0) ? 256 : int'(sc);
    len  = nsec * 512;
    irqs = 0;
    issue_cmd(c, sc, l);
    chk(st_busy && !st_ready && !st_drq, "R2 status after read command", {st_busy, st_ready, st_drq}, 3'b100);
    chk(src_req && src_lba == l, "R2 first sector request", src_lba, l);
    if (poke) begin
      rd_stb = 1'b1; rd_wide = 1'b1; cmd_valid = 1'b1; cmd_code = 8'h30;
      @(negedge clk);
      rd_stb = 1'b0; cmd_valid = 1'b0;
      chk(!rd_valid && !st_err && !irq && st_busy, "R10 strobe and command while busy ignored",
          {rd_valid, st_err, irq, st_busy}, 4'b0001);
    end
    wait_drq();
    chk(st_drq && !st_busy && st_ready, "R2 sector ready status", {st_busy, st_ready, st_drq}, 3'b011);
    idx = 0;
    while (idx < len) begin
      logic [31:0] w, e;
      bit exp_wait, exp_fire;
      int nxt;
      w = pat(l + 28'(idx / 512), (idx % 512) / 4);
      if (wide)        e = w;
      else if (idx[1]) e = {16'h0, w[31:16]};
      else             e = {16'h0, w[15:0]};
      exp_wait = (idx % 512 == 0) && (idx > 0);
      do_read(wide);
      if (exp_wait) begin
        chk(r_waited && r_busy1 && !r_drq1, "R4 stall at sector boundary", {r_waited, r_busy1, r_drq1}, 3'b110);
        chk(r_lba1 == l + 28'(idx / 512), "R4 next sector address", r_lba1, l + 28'(idx / 512));
      end else begin
        chk(!r_waited, "R4 no stall inside sector", r_waited, 0);
      end
      chk(r_valid && r_data == e, "R3 read data", r_data, e);
      nxt = idx + (wide ? 4 : 2);
      exp_fire = (nxt % (512 * blk) == 0) || (nxt == len);
      chk(r_irq == exp_fire, "R5 interrupt pacing", r_irq, exp_fire);
      if (r_irq) begin
        irqs++;
        chk(st_drq == (nxt < len) && !st_busy && st_ready, "R6 status at interrupt",
            {st_busy, st_ready, st_drq}, {2'b01, nxt < len});
      end
      idx = nxt;
    end
    chk(irqs == exp_irqs, "R5 interrupt count", irqs, exp_irqs);
  endtask

  task automatic set_mult(input logic [7:0] v, input bit exp_ok);
    issue_cmd(8'hC6, v, '0);
    if (exp_ok)
      chk(irq && !st_err && st_ready, "R8 set-multiple accepted", {irq, st_err, st_ready}, 3'b101);
    else
      chk(irq && st_err && st_ready, "R9 set-multiple abort", {irq, st_err, st_ready}, 3'b111);
  endtask

  initial begin
    int mult;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(st_ready && !st_busy && !st_drq && !st_err && !irq, "R1 reset status",
        {st_ready, st_busy, st_drq, st_err, irq}, 5'b10000);

    mult = 1;
    for (int i = 0; i < NV; i++) begin
      logic [7:0] sm, c, sc, wd, ei;
      int blk;
      {sm, c, sc, wd, ei} = VEC[i];
      if (sm != 8'hFF) begin
        set_mult(sm, 1'b1);
        mult = (sm == 0) ? 1 : int'(sm);
      end
      blk = (c == 8'hC4) ? mult : 1;
      run_xfer(c, sc, 28'h100 + 28'(i * 1024), wd[0], blk, int'(ei), 1'b0);
    end

    // R7: overrun after completed transfer, twice
    do_read(1'b1);
    chk(!r_valid && !r_irq && st_err, "R7 overrun first", {r_valid, r_irq, st_err}, 3'b001);
    do_read(1'b0);
    chk(!r_valid && !r_irq && st_err, "R7 overrun repeated", {r_valid, r_irq, st_err}, 3'b001);

    // R9: oversize value rejected, count kept
    set_mult(8'd2, 1'b1);
    set_mult(8'd17, 1'b0);
    set_mult(8'd200, 1'b0);
    run_xfer(8'hC4, 8'd4, 28'h5000, 1'b1, 2, 2, 1'b0);

    // R8: upper limit accepted
    set_mult(8'd16, 1'b1);

    // R11: unknown command aborts and ends the transfer
    issue_cmd(8'h20, 8'd2, 28'h6000);
    wait_drq();
    do_read(1'b1);
    issue_cmd(8'h30, 8'd1, '0);
    chk(irq && st_err && st_ready && !st_drq, "R11 abort status",
        {irq, st_err, st_ready, st_drq}, 4'b1110);
    do_read(1'b1);
    chk(!r_valid && st_err, "R11 transfer ended", {r_valid, st_err}, 2'b01);

    // R10: strobe and command ignored during a fetch
    run_xfer(8'h20, 8'd1, 28'h7000, 1'b1, 1, 1, 1'b1);

    // R1: multiple count back to 1 after reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(st_ready && !st_err && !st_drq, "R1 status after second reset",
        {st_ready, st_err, st_drq}, 3'b100);
    run_xfer(8'hC4, 8'd2, 28'h8000, 1'b1, 1, 2, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule